// File: doc/BRIEF.md
# Real-Time Clock Alarm Compare and Interrupt Status

This block holds the alarm registers and the interrupt status logic of a real-time clock. The host reaches it through a two-location port: one location selects a register index, the other reads or writes the selected register. A separate time-keeping core supplies the current seconds, minutes and hours bytes, and it pulses an update-ended strobe each time it finishes advancing the time. A rate generator supplies a periodic tick pulse. Neither counting nor rate division happens here.

At each update-ended strobe, while alarm checking is enabled, the three alarm bytes are compared with the current time. An alarm byte with both top bits set matches any time value. Each of the three sources (periodic, alarm, update-ended) sets its own flag and a shared summary flag in a status register. The interrupt line follows the summary flag. Reading the status register returns its contents and clears it in the same access, which also drops the interrupt.

Top module: `rtc_alm_irq`

## Requirements
- R1: After reset the index is 0, all alarm bytes read 0x00, the control register (index 11) reads 0x02, the status register (index 12) reads 0x00, the fixed register (index 13) reads 0x80 and irq_o is low.
- R2: A write with sel_data_i=0 loads wdata_i[6:0] into the index, and bit 7 is ignored. A write with sel_data_i=1 stores wdata_i into the alarm bytes at indices 1 (seconds), 3 (minutes) and 5 (hours) or into the control register at index 11. A read with sel_data_i=1 returns the stored byte on rdata_o in the same cycle.
- R3: Indices 0, 2 and 4 read back sec_i, min_i and hour_i unchanged.
- R4: On an update_end_i pulse with control bit 5 set, if every alarm byte either equals its time byte or has bits 7:6 = 11, status bits 7 and 5 are set (0xA0) at the next clock edge.
- R5: No alarm flag is set when control bit 5 is clear, when update_end_i is low, or when any non-wildcard alarm byte differs from its time byte.
- R6: An update_end_i pulse with control bit 4 set sets status bits 7 and 4 (0x90).
- R7: A periodic_i pulse with control bit 6 set sets status bits 7 and 6 (0xC0).
- R8: A data read at index 12 returns the current status value, and the status register is zero after that clock edge unless R9 applies.
- R9: A flag raised in the same cycle as a status read remains set after the clear.
- R10: Data writes to indices 12 and 13 have no effect, and index 13 always reads 0x80.
- R11: irq_o is high exactly when the status register is non-zero, and it changes at the same clock edge as the status register.
- R12: Indices other than 0 to 5 and 11 to 13 read 0x00, and data writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_data_i | input | 1 | 0 selects the index location, 1 selects the data location |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (causes side effects on the status register) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected index (combinational) |
| sec_i | input | 8 | Current seconds byte from the time core |
| min_i | input | 8 | Current minutes byte from the time core |
| hour_i | input | 8 | Current hours byte from the time core |
| update_end_i | input | 1 | Single-cycle pulse marking a completed time update |
| periodic_i | input | 1 | Single-cycle periodic rate pulse |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a status read that lands in the very cycle a new event fires. The read must return the old flags while the new flag survives the clear. The stimulus parks the index on the status register so that a read can be issued in the same cycle as the event pulses. Random loops then combine the read strobe with random periodic and update pulses, random enables and alarm bytes that often match the time or are wildcards, and a directed case pins down the exact collision.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 7;
  localparam int N_FLD = 3;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 7'd11;
  localparam logic [IDX_W-1:0] IDX_STAT  = 7'd12;
  localparam logic [IDX_W-1:0] IDX_FIXED = 7'd13;

  localparam int BIT_SUM = 7;
  localparam int BIT_PER = 6;
  localparam int BIT_ALM = 5;
  localparam int BIT_UPD = 4;

  localparam logic [DW-1:0] WILD_MASK = 8'hC0;
  localparam logic [DW-1:0] CTRL_RST  = 8'h02;
  localparam logic [DW-1:0] FIXED_VAL = 8'h80;
endpackage

// File: rtl/rtc_alm_regfile.sv
module rtc_alm_regfile
  import rtc_alm_pkg::*;
#(
  parameter int DW_P    = DW,
  parameter int IDX_W_P = IDX_W,
  parameter int N_FLD_P = N_FLD
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sel_data_i,
  input  logic                          wr_i,
  input  logic [DW_P-1:0]               wdata_i,
  output logic [IDX_W_P-1:0]            idx_o,
  output logic [N_FLD_P-1:0][DW_P-1:0]  alarm_o,
  output logic [DW_P-1:0]               ctrl_o
);
  logic idx_we, data_we;
  assign idx_we  = wr_i & ~sel_data_i;
  assign data_we = wr_i &  sel_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (idx_we) idx_o <= wdata_i[IDX_W_P-1:0];
  end

  // alarm byte f sits at odd index 2f+1
  for (genvar f = 0; f < N_FLD_P; f++) begin : g_alm
    localparam logic [IDX_W_P-1:0] MY_IDX = IDX_W_P'(2*f + 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          alarm_o[f] <= '0;
      else if (data_we && idx_o == MY_IDX)  alarm_o[f] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ctrl_o <= CTRL_RST;
    else if (data_we && idx_o == IDX_CTRL) ctrl_o <= wdata_i;
  end
endmodule

// File: rtl/rtc_alm_match.sv
module rtc_alm_match
  import rtc_alm_pkg::*;
#(
  parameter int DW_P    = DW,
  parameter int N_FLD_P = N_FLD
) (
  input  logic [N_FLD_P-1:0][DW_P-1:0] alarm_i,
  input  logic [N_FLD_P-1:0][DW_P-1:0] time_i,
  output logic                         hit_o
);
  logic [N_FLD_P-1:0] fld_hit;

  for (genvar f = 0; f < N_FLD_P; f++) begin : g_cmp
    logic wild;
    assign wild       = (alarm_i[f] & WILD_MASK) == WILD_MASK;
    assign fld_hit[f] = wild | (alarm_i[f] == time_i[f]);
  end

  assign hit_o = &fld_hit;
endmodule

// File: rtl/rtc_alm_status.sv
module rtc_alm_status
  import rtc_alm_pkg::*;
#(
  parameter int DW_P = DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            per_ev_i,
  input  logic            alm_ev_i,
  input  logic            upd_ev_i,
  input  logic            clr_i,
  output logic [DW_P-1:0] stat_o
);
  logic [DW_P-1:0] set_bits;

  always_comb begin
    set_bits = '0;
    if (per_ev_i) begin set_bits[BIT_PER] = 1'b1; set_bits[BIT_SUM] = 1'b1; end
    if (alm_ev_i) begin set_bits[BIT_ALM] = 1'b1; set_bits[BIT_SUM] = 1'b1; end
    if (upd_ev_i) begin set_bits[BIT_UPD] = 1'b1; set_bits[BIT_SUM] = 1'b1; end
  end

  // new events win over the read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_o <= '0;
    else if (clr_i) stat_o <= set_bits;
    else            stat_o <= stat_o | set_bits;
  end
endmodule

// File: rtl/rtc_alm_irq.sv
module rtc_alm_irq
  import rtc_alm_pkg::*;
#(
  parameter int DW_P    = DW,
  parameter int IDX_W_P = IDX_W,
  parameter int N_FLD_P = N_FLD
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_data_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [DW_P-1:0] wdata_i,
  output logic [DW_P-1:0] rdata_o,
  input  logic [DW_P-1:0] sec_i,
  input  logic [DW_P-1:0] min_i,
  input  logic [DW_P-1:0] hour_i,
  input  logic            update_end_i,
  input  logic            periodic_i,
  output logic            irq_o
);
  logic [IDX_W_P-1:0]           idx_q;
  logic [N_FLD_P-1:0][DW_P-1:0] alarm_q;
  logic [N_FLD_P-1:0][DW_P-1:0] time_w;
  logic [DW_P-1:0]              ctrl_q;
  logic [DW_P-1:0]              status_q;
  logic                         alm_hit, stat_rd;

  assign time_w[0] = sec_i;
  assign time_w[1] = min_i;
  assign time_w[2] = hour_i;

  rtc_alm_regfile #(.DW_P(DW_P), .IDX_W_P(IDX_W_P), .N_FLD_P(N_FLD_P)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_data_i (sel_data_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .idx_o      (idx_q),
    .alarm_o    (alarm_q),
    .ctrl_o     (ctrl_q)
  );

  rtc_alm_match #(.DW_P(DW_P), .N_FLD_P(N_FLD_P)) u_match (
    .alarm_i (alarm_q),
    .time_i  (time_w),
    .hit_o   (alm_hit)
  );

  assign stat_rd = rd_i & sel_data_i & (idx_q == IDX_STAT);

  rtc_alm_status #(.DW_P(DW_P)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .per_ev_i (periodic_i & ctrl_q[BIT_PER]),
    .alm_ev_i (update_end_i & ctrl_q[BIT_ALM] & alm_hit),
    .upd_ev_i (update_end_i & ctrl_q[BIT_UPD]),
    .clr_i    (stat_rd),
    .stat_o   (status_q)
  );

  assign irq_o = status_q[BIT_SUM];

  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < N_FLD_P; f++) begin
      if (idx_q == IDX_W_P'(2*f))     rdata_o = time_w[f];
      if (idx_q == IDX_W_P'(2*f + 1)) rdata_o = alarm_q[f];
    end
    if (idx_q == IDX_CTRL)  rdata_o = ctrl_q;
    if (idx_q == IDX_STAT)  rdata_o = status_q;
    if (idx_q == IDX_FIXED) rdata_o = FIXED_VAL;
  end
endmodule

// File: rtl/rtc_alm_irq_chk.sv
module rtc_alm_irq_chk
  import rtc_alm_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_data_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic       update_end_i,
  input logic       periodic_i,
  input logic       irq_o,
  input logic [6:0] idx_i,
  input logic [7:0] ctrl_i,
  input logic [7:0] stat_i
);
  logic stat_rd;
  assign stat_rd = rd_i & sel_data_i & (idx_i == IDX_STAT);

  // R7
  periodic_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periodic_i && ctrl_i[BIT_PER]) |=> (irq_o && stat_i[BIT_PER]));

  // R6
  update_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_end_i && ctrl_i[BIT_UPD]) |=> (irq_o && stat_i[BIT_UPD]));

  // R8
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !update_end_i && !periodic_i) |=> (stat_i == 8'h00 && !irq_o));

  // R10
  stat_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_data_i && idx_i == IDX_STAT && !update_end_i && !periodic_i)
      |=> $stable(stat_i));

  // R5
  no_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_rd && !stat_i[BIT_ALM] && !(update_end_i && ctrl_i[BIT_ALM]))
      |=> !stat_i[BIT_ALM]);

  // R11
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(stat_rd));
endmodule

bind rtc_alm_irq rtc_alm_irq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_data_i   (sel_data_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .update_end_i (update_end_i),
  .periodic_i   (periodic_i),
  .irq_o        (irq_o),
  .idx_i        (idx_q),
  .ctrl_i       (ctrl_q),
  .stat_i       (status_q)
);

// File: tb/rtc_alm_irq_test.sv
module rtc_alm_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] sec = '0, mn = '0, hr = '0;
  logic       upd = 1'b0, per = 1'b0, irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_alm [3];
  logic [7:0] m_ctrl, m_stat;

  rtc_alm_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_data_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sec_i(sec), .min_i(mn), .hour_i(hr),
    .update_end_i(upd), .periodic_i(per), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    sel = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(output logic [7:0] d);
    sel = 1'b1; rd = 1'b1;
    #5 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_idx(input logic [7:0] i, output logic [7:0] d);
    wr_reg(1'b0, i);
    rd_reg(d);
  endtask

  function automatic logic alm_hit(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    logic [7:0] t [3];
    t[0] = s; t[1] = m; t[2] = h;
    alm_hit = 1'b1;
    for (int f = 0; f < 3; f++)
      if (!(m_alm[f][7:6] == 2'b11 || m_alm[f] == t[f])) alm_hit = 1'b0;
  endfunction

  function automatic logic [7:0] new_bits(input logic u, input logic p, input logic hit);
    new_bits = 8'h00;
    if (p && m_ctrl[6])            new_bits |= 8'hC0;
    if (u && m_ctrl[4])            new_bits |= 8'h90;
    if (u && m_ctrl[5] && hit)     new_bits |= 8'hA0;
  endfunction

  // one event cycle with index parked on status; optional simultaneous read
  task automatic event_cyc(input logic u, input logic p, input logic rdc);
    logic [7:0] nb;
    nb = new_bits(u, p, alm_hit(sec, mn, hr));
    upd = u; per = p; sel = 1'b1; rd = rdc;
    #5 if (rdc) check("R8 read-before-clear", rdata, m_stat);
    @(negedge clk);
    upd = 1'b0; per = 1'b0; rd = 1'b0;
    m_stat = (rdc ? 8'h00 : m_stat) | nb;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    m_alm[0] = 0; m_alm[1] = 0; m_alm[2] = 0;
    m_ctrl = 8'h02; m_stat = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state (index 0 reads sec_i = 0)
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd_reg(d);            check("R1 index0", d, 8'h00);
    rd_idx(8'd1, d);      check("R1 alarm sec", d, 8'h00);
    rd_idx(8'd5, d);      check("R1 alarm hour", d, 8'h00);
    rd_idx(8'd11, d);     check("R1 ctrl", d, 8'h02);
    rd_idx(8'd12, d);     check("R1 status", d, 8'h00);
    rd_idx(8'd13, d);     check("R1 fixed", d, 8'h80);

    // R10 writes to status and fixed ignored
    wr_reg(1'b0, 8'd12); wr_reg(1'b1, 8'hFF);
    check("R10 irq after status write", {7'b0, irq}, 8'h00);
    rd_reg(d); check("R10 status", d, 8'h00);
    wr_reg(1'b0, 8'd13); wr_reg(1'b1, 8'h00);
    rd_reg(d); check("R10 fixed", d, 8'h80);

    // R12 unmapped index
    wr_reg(1'b0, 8'd20); wr_reg(1'b1, 8'h55);
    rd_reg(d); check("R12 unmapped", d, 8'h00);
    rd_idx(8'd11, d); check("R12 ctrl untouched", d, 8'h02);

    // R2 index bit 7 ignored
    wr_reg(1'b0, 8'h83); wr_reg(1'b1, 8'h33); m_alm[1] = 8'h33;
    rd_idx(8'd3, d); check("R2 index bit7", d, 8'h33);

    // R3 time passthrough
    sec = 8'h59; mn = 8'h12; hr = 8'h87;
    rd_idx(8'd0, d); check("R3 sec", d, 8'h59);
    rd_idx(8'd2, d); check("R3 min", d, 8'h12);
    rd_idx(8'd4, d); check("R3 hour", d, 8'h87);

    // R5 / R4 directed: all wildcards, AIE on
    for (int f = 0; f < 3; f++) begin
      wr_reg(1'b0, 8'(2*f+1)); wr_reg(1'b1, 8'hC5); m_alm[f] = 8'hC5;
    end
    wr_reg(1'b0, 8'd11); wr_reg(1'b1, 8'h20); m_ctrl = 8'h20;
    wr_reg(1'b0, 8'd12);
    event_cyc(1'b0, 1'b1, 1'b0);
    rd_reg(d); check("R5 no update no alarm", d, 8'h00);
    event_cyc(1'b1, 1'b0, 1'b0);
    check("R11 irq on alarm", {7'b0, irq}, 8'h01);
    rd_reg(d); check("R4 wildcard alarm", d, 8'hA0);
    check("R8 irq low after read", {7'b0, irq}, 8'h00);
    m_stat = 8'h00;

    // R9 collision: pending update flag, read with periodic event
    wr_reg(1'b0, 8'd11); wr_reg(1'b1, 8'h50); m_ctrl = 8'h50;
    wr_reg(1'b0, 8'd12);
    event_cyc(1'b1, 1'b0, 1'b0);
    event_cyc(1'b0, 1'b1, 1'b1);
    check("R9 irq kept", {7'b0, irq}, 8'h01);
    rd_reg(d); check("R9 survives clear", d, 8'hC0);
    m_stat = 8'h00;

    // random
    for (int it = 0; it < 400; it++) begin
      logic u, p, rc;
      logic [7:0] tv [3];
      for (int f = 0; f < 3; f++) begin
        logic [7:0] a;
        a = 8'($urandom);
        if ($urandom_range(3) == 0) a = a | 8'hC0;
        else a = a & 8'h7F;
        m_alm[f] = a;
        tv[f] = ($urandom_range(3) != 0) ? (a & 8'h7F) : 8'($urandom);
        wr_reg(1'b0, 8'(2*f+1)); wr_reg(1'b1, a);
      end
      m_ctrl = 8'($urandom);
      wr_reg(1'b0, 8'd11); wr_reg(1'b1, m_ctrl);
      rd_reg(d); check("R2 ctrl readback", d, m_ctrl);
      wr_reg(1'b0, 8'd12);
      sec = tv[0]; mn = tv[1]; hr = tv[2];
      u = 1'($urandom); p = 1'($urandom); rc = ($urandom_range(2) == 0);
      event_cyc(u, p, rc);
      check("R11 irq", {7'b0, irq}, {7'b0, (m_stat != 0)});
      if ($urandom_range(1) == 0) begin
        rd_reg(d); check("R4 R6 R7 status", d, m_stat);
        m_stat = 8'h00;
        check("R8 cleared irq", {7'b0, irq}, 8'h00);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule